// File: doc/BRIEF.md
# Two-Stage Skip and Signature Prefilter

This block screens a byte stream against a pattern set that was loaded beforehand. It sits in front of an exact matcher and keeps most traffic away from it. Bytes collect in a four-byte window. Once the window is full, a ternary shift table is searched in a single cycle. If an entry hits and its skip count is not zero, the window slides forward by that many bytes. If the search misses, or the hit carries a skip of zero, a second ternary table of signatures is searched. A window that no signature matches is dropped as safe and slides by one byte. A window that a signature matches is passed downstream as a candidate, tagged with its stream offset.

The tables and the skip memory are written through a plain load port while scanning is off. The byte input uses a valid/ready handshake. A byte transfers on a clock edge when `in_valid` and `in_ready` are both high. `in_ready` goes low when the window is full, when scanning is off, or when a candidate is held waiting. The candidate output also uses valid/ready. Once `cand_valid` is raised, the offset and index stay stable until `cand_ready` is seen high on a clock edge. While a candidate waits, the engine makes no progress at all.

Top module: `skipsig_filter`

## Requirements
- R1: An entry matches when it has been written since reset and every window bit whose mask bit is 0 equals the stored bit; mask bit 1 marks a don't-care bit. After reset both tables are empty.
- R2: The window holds the four oldest unconsumed bytes. The oldest byte sits in bits [7:0] and the byte at offset base+i sits in bits [8i+7:8i]. The candidate offset is the stream offset of the oldest byte, counted from reset.
- R3: When several entries of one table match, the entry with the lowest index is the one used, in both tables.
- R4: A shift-table hit whose stored skip k is 1 to 4 consumes k bytes and raises no candidate. Stored values 5 to 7 act as 4.
- R5: A shift miss, or a shift hit with skip 0, leads to a signature search. A signature miss consumes one byte and raises no candidate.
- R6: A signature hit raises `cand_valid` on the next cycle, with the window offset and the hitting signature index, and consumes one byte.
- R7: While `cand_valid` is high and `cand_ready` is low, the candidate fields hold, `in_ready` is low and no window is evaluated.
- R8: Table writes (`tbl_sel` 0 = shift table plus skip memory, 1 = signature table) take effect only while `scan_en` is low. While `scan_en` is low, `in_ready` is low, nothing is evaluated and the offset does not move.
- R9: After reset `cand_valid` is low and the offset is 0. `in_ready` is high as soon as `scan_en` is high.
- R10: A full window is evaluated in the cycle it is full, unless stalled. `in_ready` is high only while fewer than four bytes are held, so filling and evaluation take turns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also restarts the stream offset |
| scan_en | input | 1 | Scanning on (1) or table-load mode (0) |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high together with in_valid |
| in_data | input | 8 | Input byte |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 1 | 0 selects the shift table and skip memory, 1 selects the signature table |
| tbl_addr | input | 5 | Entry index |
| tbl_value | input | 32 | Stored bits, laid out like the window |
| tbl_mask | input | 32 | Per-bit don't-care flags |
| tbl_skip | input | 3 | Skip count, written with a shift-table entry |
| cand_valid | output | 1 | Candidate available |
| cand_ready | input | 1 | Downstream takes the candidate |
| cand_offset | output | 32 | Stream offset of the candidate window's oldest byte |
| cand_sig_idx | output | 5 | Index of the signature entry that hit |

## Verification
The bench builds the block with its default parameters: a four-byte window, 32 entries per table and 3-bit skips. This covers every skip value, including the clamped ones, and lets entries overlap so that priority is exercised. Windows are built to hit shifted entries, entries that skip by zero, ternary entries and duplicated signatures. The streams are fed with random input gaps, random stalls on the candidate side and toggling of scan mode. This brings stalls during evaluation, writes attempted during scanning, and windows left over between phases all within reach.

// File: rtl/filt_pkg.sv
package filt_pkg;
  typedef enum logic {
    TBL_SHIFT = 1'b0,
    TBL_SIG   = 1'b1
  } tbl_sel_e;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_SKIP = 2'd1,
    ACT_DROP = 2'd2,
    ACT_CAND = 2'd3
  } act_e;
endpackage

// File: rtl/prio_enc.sv
module prio_enc #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  output logic             hit,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    hit = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/skip_mem.sv
module skip_mem #(
  parameter int ENTRIES = 32,
  parameter int SKIP_W  = 3,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [SKIP_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_addr,
  output logic [SKIP_W-1:0] rd_data
);
  logic [SKIP_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/tcam_bank.sv
module tcam_bank #(
  parameter int ENTRIES = 32,
  parameter int KEY_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic [KEY_W-1:0] key,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);
  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] match;
  logic [KEY_W-1:0]   value_q [ENTRIES];
  logic [KEY_W-1:0]   mask_q  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
      end else if (wr_en && wr_addr == IDX_W'(g)) begin
        valid_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_addr == IDX_W'(g)) begin
        value_q[g] <= wr_value;
        mask_q[g]  <= wr_mask;
      end
    end

    assign match[g] = valid_q[g] && (((key ^ value_q[g]) & ~mask_q[g]) == '0);
  end

  prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_prio (
    .req (match),
    .hit (hit),
    .idx (hit_idx)
  );

  // R8: entries only come alive through a write strobe
  p_tbl_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(valid_q));
endmodule

// File: rtl/skipsig_filter.sv
module skipsig_filter
  import filt_pkg::*;
#(
  parameter int WIN_BYTES = 4,
  parameter int ENTRIES   = 32,
  parameter int SKIP_W    = 3,
  parameter int OFF_W     = 32,
  localparam int KEY_W    = 8 * WIN_BYTES,
  localparam int IDX_W    = $clog2(ENTRIES),
  localparam int FILL_W   = $clog2(WIN_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              tbl_we,
  input  logic              tbl_sel,
  input  logic [IDX_W-1:0]  tbl_addr,
  input  logic [KEY_W-1:0]  tbl_value,
  input  logic [KEY_W-1:0]  tbl_mask,
  input  logic [SKIP_W-1:0] tbl_skip,
  output logic              cand_valid,
  input  logic              cand_ready,
  output logic [OFF_W-1:0]  cand_offset,
  output logic [IDX_W-1:0]  cand_sig_idx
);
  logic [KEY_W-1:0]  win_q;
  logic [FILL_W-1:0] fill_q;
  logic [OFF_W-1:0]  off_q;

  logic              stall, win_full, eval, wr_ok;
  logic              sh_we, sg_we;
  logic              sh_hit, sg_hit;
  logic [IDX_W-1:0]  sh_idx, sg_idx;
  logic [SKIP_W-1:0] skip_raw;
  logic [FILL_W-1:0] skip_eff, adv;
  act_e              act;

  assign stall    = cand_valid && !cand_ready;
  assign win_full = (fill_q == FILL_W'(WIN_BYTES));
  assign in_ready = scan_en && !win_full && !stall;
  assign eval     = scan_en && win_full && !stall;
  assign wr_ok    = tbl_we && !scan_en;
  assign sh_we    = wr_ok && (tbl_sel_e'(tbl_sel) == TBL_SHIFT);
  assign sg_we    = wr_ok && (tbl_sel_e'(tbl_sel) == TBL_SIG);

  tcam_bank #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_shift_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (sh_we),
    .wr_addr  (tbl_addr),
    .wr_value (tbl_value),
    .wr_mask  (tbl_mask),
    .key      (win_q),
    .hit      (sh_hit),
    .hit_idx  (sh_idx)
  );

  skip_mem #(.ENTRIES(ENTRIES), .SKIP_W(SKIP_W)) u_skip (
    .clk     (clk),
    .wr_en   (sh_we),
    .wr_addr (tbl_addr),
    .wr_data (tbl_skip),
    .rd_addr (sh_idx),
    .rd_data (skip_raw)
  );

  tcam_bank #(.ENTRIES(ENTRIES), .KEY_W(KEY_W)) u_sig_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (sg_we),
    .wr_addr  (tbl_addr),
    .wr_value (tbl_value),
    .wr_mask  (tbl_mask),
    .key      (win_q),
    .hit      (sg_hit),
    .hit_idx  (sg_idx)
  );

  // stored skips beyond the window width are clamped to a full-window slide
  always_comb begin
    if (int'(skip_raw) > WIN_BYTES) skip_eff = FILL_W'(WIN_BYTES);
    else                            skip_eff = FILL_W'(skip_raw);
  end

  always_comb begin
    if (!eval)                          act = ACT_NONE;
    else if (sh_hit && skip_eff != '0)  act = ACT_SKIP;
    else if (sg_hit)                    act = ACT_CAND;
    else                                act = ACT_DROP;
  end

  assign adv = (act == ACT_SKIP) ? skip_eff : FILL_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
      off_q  <= '0;
    end else if (in_valid && in_ready) begin
      win_q[{fill_q, 3'b000} +: 8] <= in_data;
      fill_q <= fill_q + FILL_W'(1);
    end else if (act != ACT_NONE) begin
      win_q  <= win_q >> {adv, 3'b000};
      fill_q <= fill_q - adv;
      off_q  <= off_q + OFF_W'(adv);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand_valid   <= 1'b0;
      cand_offset  <= '0;
      cand_sig_idx <= '0;
    end else if (act == ACT_CAND) begin
      cand_valid   <= 1'b1;
      cand_offset  <= off_q;
      cand_sig_idx <= sg_idx;
    end else if (cand_ready) begin
      cand_valid   <= 1'b0;
    end
  end

  p_cand_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid && !cand_ready |=> cand_valid && $stable(cand_offset) && $stable(cand_sig_idx));

  p_idle_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> $stable(off_q));

  p_fill_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FILL_W'(WIN_BYTES));

  p_progress_r5: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en && win_full && !stall |=> fill_q != FILL_W'(WIN_BYTES));
endmodule

// File: tb/skipsig_filter_tb.sv
module skipsig_filter_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scan_en = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        tbl_we = 1'b0;
  logic        tbl_sel = 1'b0;
  logic [4:0]  tbl_addr = '0;
  logic [31:0] tbl_value = '0;
  logic [31:0] tbl_mask = '0;
  logic [2:0]  tbl_skip = '0;
  logic        cand_valid;
  logic        cand_ready = 1'b1;
  logic [31:0] cand_offset;
  logic [4:0]  cand_sig_idx;

  always #5 clk = ~clk;

  skipsig_filter u_dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_addr(tbl_addr), .tbl_value(tbl_value), .tbl_mask(tbl_mask),
    .tbl_skip(tbl_skip), .cand_valid(cand_valid), .cand_ready(cand_ready),
    .cand_offset(cand_offset), .cand_sig_idx(cand_sig_idx)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  string cur_req = "R9";
  int unsigned rnd = 32'h1234_5678;

  // reference model state
  logic [7:0]  m_q [$];
  logic [7:0]  stim [$];
  int          m_base;
  bit          m_cv, m_acc;
  int          m_off, m_idx;
  logic [31:0] sv [32], sm [32], gv [32], gm [32];
  int          sk [32];
  bit          svld [32], gvld [32];

  function automatic int unsigned next_rnd();
    rnd = rnd * 32'd1103515245 + 32'd12345;
    return rnd >> 8;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    m_acc = 1'b0;
    if (!rst_n) begin
      m_q.delete();
      m_base = 0; m_cv = 0; m_off = 0; m_idx = 0;
      for (int i = 0; i < 32; i++) begin svld[i] = 0; gvld[i] = 0; end
    end else begin
      bit stl;
      stl = m_cv && !cand_ready;
      if (tbl_we && !scan_en) begin
        if (tbl_sel == 1'b0) begin
          sv[tbl_addr] = tbl_value; sm[tbl_addr] = tbl_mask;
          sk[tbl_addr] = int'(tbl_skip); svld[tbl_addr] = 1;
        end else begin
          gv[tbl_addr] = tbl_value; gm[tbl_addr] = tbl_mask; gvld[tbl_addr] = 1;
        end
      end
      if (m_cv && cand_ready) m_cv = 0;
      if (scan_en && !stl) begin
        if (m_q.size() < 4) begin
          if (in_valid) begin m_q.push_back(in_data); m_acc = 1'b1; end
        end else begin
          logic [31:0] w;
          int sh, sg, skp, adv;
          w = {m_q[3], m_q[2], m_q[1], m_q[0]};
          sh = -1; sg = -1;
          for (int i = 31; i >= 0; i--) begin
            if (svld[i] && (((w ^ sv[i]) & ~sm[i]) == 0)) sh = i;
            if (gvld[i] && (((w ^ gv[i]) & ~gm[i]) == 0)) sg = i;
          end
          skp = (sh >= 0) ? ((sk[sh] > 4) ? 4 : sk[sh]) : 0;
          if (skp > 0) adv = skp;
          else begin
            adv = 1;
            if (sg >= 0) begin m_cv = 1; m_off = m_base; m_idx = sg; end
          end
          for (int i = 0; i < adv; i++) void'(m_q.pop_front());
          m_base += adv;
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      bit exp_rdy;
      exp_rdy = scan_en && (m_q.size() < 4) && !(m_cv && !cand_ready);
      chk(cur_req, "in_ready", in_ready, exp_rdy);
      chk(cur_req, "cand_valid", cand_valid, m_cv);
      if (cand_valid && m_cv) begin
        chk(cur_req, "cand_offset", cand_offset, m_off);
        chk(cur_req, "cand_sig_idx", cand_sig_idx, m_idx);
      end
    end
  end

  task automatic load(input bit sel, input int addr, input logic [31:0] v,
                      input logic [31:0] m, input int s);
    @(negedge clk);
    tbl_we = 1'b1; tbl_sel = sel; tbl_addr = 5'(addr);
    tbl_value = v; tbl_mask = m; tbl_skip = 3'(s);
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic push_str(input string s);
    for (int i = 0; i < s.len(); i++) stim.push_back(s[i]);
  endtask

  // gap: percent of idle input cycles; stall: percent of cycles with cand_ready low
  task automatic feed(input int gap, input int stall, input int scan_off);
    while (stim.size() > 0) begin
      @(negedge clk);
      if (m_acc) void'(stim.pop_front());
      scan_en    = (int'(next_rnd() % 100) >= scan_off);
      cand_ready = (int'(next_rnd() % 100) >= stall);
      if (stim.size() > 0) begin
        in_valid = (int'(next_rnd() % 100) >= gap);
        in_data  = stim[0];
      end else begin
        in_valid = 1'b0;
      end
    end
    in_valid = 1'b0;
    scan_en = 1'b1;
    cand_ready = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state with scanning off, then ready once scanning is on
    chk("R9", "cand_valid after reset", cand_valid, 0);
    chk("R9", "in_ready with scan off", in_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    scan_en = 1'b1;
    #1;
    chk("R9", "in_ready with scan on", in_ready, 1);
    // R1: empty tables raise nothing
    cur_req = "R1";
    push_str("DEAD"); push_str("Bz Q");
    feed(0, 0, 0);
    chk("R1", "no candidate from empty tables", cand_valid, 0);

    scan_en = 1'b0;
    cur_req = "R8";
    load(0, 0, 32'h0000_0041, 32'hFFFF_FF00, 3);
    load(0, 1, 32'h0000_0042, 32'hFFFF_FF00, 0);
    load(0, 2, 32'h0000_0043, 32'hFFFF_FF00, 7);
    load(0, 3, 32'h0000_0041, 32'hFFFF_FF00, 1);
    load(0, 4, 32'h0000_5A00, 32'hFFFF_00FF, 2);
    load(1, 0, 32'h5100_0042, 32'h00FF_FF00, 0);
    load(1, 1, 32'h4441_4544, 32'h0000_0000, 0);
    load(1, 2, 32'h4441_4544, 32'h0000_0000, 0);
    load(1, 5, 32'h0000_0010, 32'hFFFF_FF06, 0);

    cur_req = "R1";
    stim.push_back(8'h10); stim.push_back(8'h12); stim.push_back(8'h16);
    stim.push_back(8'h11); stim.push_back(8'h14); stim.push_back(8'h90);
    stim.push_back(8'h01); stim.push_back(8'h02); stim.push_back(8'h03);
    feed(0, 0, 0);

    cur_req = "R2";
    push_str("xZyyxxZZqrstuvw");
    feed(0, 0, 0);

    cur_req = "R4";
    push_str("AbcdefgCabcdefgAAAACCCCxyzw");
    feed(0, 0, 0);

    cur_req = "R3";
    push_str("..DEAD..DEADDEAD....");
    feed(0, 0, 0);

    cur_req = "R5";
    push_str("Bxyz Bq Q BBBQ ghij");
    feed(0, 0, 0);

    cur_req = "R6";
    push_str("kkDEADkBabQ\x10\x12\x14\x16mmmm");
    feed(0, 0, 0);

    cur_req = "R7";
    for (int i = 0; i < 40; i++) push_str("DEAD");
    push_str("abcd");
    feed(10, 70, 0);

    cur_req = "R8";
    @(negedge clk);
    scan_en = 1'b1;
    tbl_we = 1'b1; tbl_sel = 1'b1; tbl_addr = 5'd6;
    tbl_value = 32'h5A59_5857; tbl_mask = '0;
    @(negedge clk);
    tbl_we = 1'b0;
    push_str("WXYZWXYZ....");
    feed(0, 0, 0);
    for (int i = 0; i < 20; i++) push_str("DEADBxxQ");
    feed(0, 20, 30);

    cur_req = "R10";
    for (int i = 0; i < 300; i++) stim.push_back(8'(next_rnd()));
    for (int i = 0; i < 10; i++) push_str("ADEAD");
    feed(40, 30, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule